// File: doc/BRIEF.md
# I2C Slave Address-Match Status Unit

This unit sits beside the bit-level engine of an I2C slave port. It receives START, repeated-START and STOP strobes that are already decoded, every received byte with a strobe, and event strobes from the slave FIFOs. It compares the first byte after each START against four programmable slave addresses and decodes general calls. From these inputs it keeps a 32-bit status word and one interrupt line. It also issues a one-cycle pulse when a general-call reset is received. SCL/SDA sampling, shifting and FIFO storage stay in the neighbouring logic.

Each status flag has its own set and clear rule. Software clears some flags by reading the status word. Others clear through FIFO data accesses or through a dedicated clear strobe driven from the configuration register. If a set event and a clear event reach a flag in the same cycle, the set wins, so no event is lost. Every flag change appears on `status` one cycle after the strobe that caused it.

Top module: `i2cs_stat_top`

## Requirements
- R1: After a START, the next received byte `{addr[6:0], rw}` whose `addr` equals one of `slaveIds[7i+6:7i]` sets start bit 14 and busy bit 6, and writes the index of the matching ID to bits 12:11. If several IDs are equal, the lowest index is reported. A byte that matches nothing, or a byte received with no START before it, changes none of these bits.
- R2: A repeated START followed by a matching byte sets bit 13 and loads the ID field. It does not change bit 14. Bit 13 clears on a status read or on a STOP.
- R3: A STOP clears bits 14, 13 and 6. If a matching address (ID or general call) has been accepted since the previous STOP, the STOP also sets the stop-after-match interrupt, bit 10. A STOP with no such match does not set bit 10. Bit 10 clears on a status read.
- R4: An address byte of 0x00 is treated as a general call only when `gcEnable` is 1. A general call sets bit 7 and bit 6. Bit 7 stays set until `gcClearStb` is pulsed.
- R5: The byte that follows an accepted general call loads the general-call type into bits 9:8 as follows. 0x06 gives 01 (reset and program address). 0x04 gives 10 (program address). An odd byte whose upper seven bits equal `altId` gives 11. Any other byte gives 00. `gcClearStb` returns the field to 00.
- R6: A type-01 general call raises `gcResetPulse` for exactly one cycle. In the same cycle, every status bit except 9:8 and 7 returns to its reset value.
- R7: `noDataStb` sets no-ack bit 5 and `rxOverflowStb` sets overflow bit 4. A status read clears both.
- R8: `rxDataStb` sets receive-interrupt bit 3. Either `rxReadStb` or `rxFlushStb` clears it.
- R9: `txDoneStb` sets bit 2, `txUnderflowStb` sets bit 1 and `txEmptyStb` sets bit 0. A `txWriteStb` clears all three. After reset, bit 0 is 1 and every other bit is 0 (status = 0x00000001).
- R10: Bits 31:15 always read 0.
- R11: `irq` is 1 exactly when any of bits 2, 3, 7 or 10 is set.
- R12: When a set strobe and a clear strobe reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | START detected |
| rptStartStb | input | 1 | Repeated START detected |
| stopStb | input | 1 | STOP detected |
| byteStb | input | 1 | A received byte is valid on rxByte |
| rxByte | input | 8 | Received byte; for addresses bit 0 is the direction |
| slaveIds | input | 28 | Four 7-bit slave addresses, ID i in bits 7i+6:7i |
| altId | input | 7 | Alternative ID used for type-11 general calls |
| gcEnable | input | 1 | Accept the general-call address |
| gcClearStb | input | 1 | Clears the general-call interrupt and type |
| statusRd | input | 1 | Status word is being read |
| noDataStb | input | 1 | Master asked for data and none was available |
| rxOverflowStb | input | 1 | Receive FIFO overflowed |
| rxDataStb | input | 1 | A data byte entered the receive FIFO |
| rxReadStb | input | 1 | Receive data register read |
| rxFlushStb | input | 1 | Receive FIFO flushed |
| txDoneStb | input | 1 | Transmission finished |
| txWriteStb | input | 1 | Transmit data register written |
| txEmptyStb | input | 1 | Transmit FIFO became empty |
| txUnderflowStb | input | 1 | Transmit FIFO underflowed |
| status | output | 32 | Status word |
| irq | output | 1 | Interrupt request |
| gcResetPulse | output | 1 | One-cycle general-call reset pulse |

## Verification
The general-call reset is the hardest case to observe. The bench can only check that flags return to their defaults if some flags were set before the reset byte arrives. So for every possible second byte of a general call, the bench first raises the no-ack flag. It then sends the second byte and checks the no-ack flag, the busy flag, the type field and the reset pulse together. Priority among duplicate IDs is covered by programming two equal IDs and sweeping all 128 addresses.

// File: rtl/i2cs_stat_pkg.sv
package i2cs_stat_pkg;

  // Bit positions inside the status word (software decodes them)
  localparam int BIT_TX_EMPTY = 0;
  localparam int BIT_TX_UNF   = 1;
  localparam int BIT_TX_IRQ   = 2;
  localparam int BIT_RX_IRQ   = 3;
  localparam int BIT_RX_OVF   = 4;
  localparam int BIT_NOACK    = 5;
  localparam int BIT_BUSY     = 6;
  localparam int BIT_GC_IRQ   = 7;
  localparam int BIT_GC_TYPE  = 8;
  localparam int BIT_STOP_IRQ = 10;
  localparam int BIT_ID       = 11;
  localparam int BIT_RPT      = 13;
  localparam int BIT_START    = 14;
  localparam int USED_BITS    = 15;

  // Strobes from the sequencing control to the flag datapath
  typedef struct packed {
    logic setStart;
    logic setRpt;
    logic loadId;
    logic setBusy;
    logic stopEvt;
    logic stopMatched;
    logic setGc;
    logic loadGcType;
    logic gcReset;
  } ctrlStb_t;

endpackage

// File: rtl/i2cs_stat_ctrl.sv
module i2cs_stat_ctrl
  import i2cs_stat_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startStb,
  input  logic     rptStartStb,
  input  logic     stopStb,
  input  logic     byteStb,
  input  logic     gcEnable,
  input  logic     idHit,
  input  logic     gcAddrHit,
  input  logic [1:0] gcTypeDec,
  output ctrlStb_t stb,
  output logic     gcResetPulse
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_MATCH, S_GC2, S_SKIP} seqState_t;

  seqState_t state, nextState;
  logic      isRpt, nextRpt;
  logic      matchedRun, nextRun;

  always_comb begin
    stb       = '0;
    nextState = state;
    nextRpt   = isRpt;
    nextRun   = matchedRun;
    if (stopStb) begin
      stb.stopEvt     = 1'b1;
      stb.stopMatched = matchedRun;
      nextState       = S_IDLE;
      nextRun         = 1'b0;
    end else if (startStb || rptStartStb) begin
      nextState = S_ADDR;
      nextRpt   = rptStartStb;
    end else if (byteStb) begin
      case (state)
        S_ADDR: begin
          if (idHit) begin
            stb.loadId  = 1'b1;
            stb.setBusy = 1'b1;
            stb.setStart = !isRpt;
            stb.setRpt   = isRpt;
            nextRun     = 1'b1;
            nextState   = S_MATCH;
          end else if (gcAddrHit && gcEnable) begin
            stb.setGc   = 1'b1;
            stb.setBusy = 1'b1;
            nextRun     = 1'b1;
            nextState   = S_GC2;
          end else begin
            nextState = S_SKIP;
          end
        end
        S_GC2: begin
          stb.loadGcType = 1'b1;
          stb.gcReset    = (gcTypeDec == 2'b01);
          nextState      = S_MATCH;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      isRpt        <= 1'b0;
      matchedRun   <= 1'b0;
      gcResetPulse <= 1'b0;
    end else begin
      state        <= nextState;
      isRpt        <= nextRpt;
      matchedRun   <= nextRun;
      gcResetPulse <= stb.gcReset;
    end
  end

endmodule

// File: rtl/i2cs_stat_dpath.sv
module i2cs_stat_dpath
  import i2cs_stat_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int NUM_IDS = 4,
  parameter int STAT_W  = 32,
  localparam int IDX_W  = $clog2(NUM_IDS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W:0]           rxByte,
  input  logic [NUM_IDS*ADDR_W-1:0] slaveIds,
  input  logic [ADDR_W-1:0]         altId,
  input  ctrlStb_t                  stb,
  input  logic                      gcClearStb,
  input  logic                      statusRd,
  input  logic                      noDataStb,
  input  logic                      rxOverflowStb,
  input  logic                      rxDataStb,
  input  logic                      rxReadStb,
  input  logic                      rxFlushStb,
  input  logic                      txDoneStb,
  input  logic                      txWriteStb,
  input  logic                      txEmptyStb,
  input  logic                      txUnderflowStb,
  output logic                      idHit,
  output logic                      gcAddrHit,
  output logic [1:0]                gcTypeDec,
  output logic [STAT_W-1:0]         status,
  output logic                      irq
);

  logic [ADDR_W-1:0] rxAddr;
  logic              rxDir;
  logic [NUM_IDS-1:0] hitVec;
  logic [IDX_W-1:0]   idIdx;

  assign rxAddr = rxByte[ADDR_W:1];
  assign rxDir  = rxByte[0];

  // One comparator per programmable ID
  for (genvar i = 0; i < NUM_IDS; i++) begin : g_cmp
    assign hitVec[i] = (rxAddr == slaveIds[i*ADDR_W +: ADDR_W]);
  end

  // Lowest index wins
  always_comb begin
    idHit = 1'b0;
    idIdx = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        idHit = 1'b1;
        idIdx = IDX_W'(i);
      end
    end
  end

  assign gcAddrHit = (rxAddr == '0) && !rxDir;

  always_comb begin
    if (rxByte == (ADDR_W+1)'(6))      gcTypeDec = 2'b01;
    else if (rxByte == (ADDR_W+1)'(4)) gcTypeDec = 2'b10;
    else if (rxDir && rxAddr == altId) gcTypeDec = 2'b11;
    else                               gcTypeDec = 2'b00;
  end

  logic             startF, rptF, busyF, stopIrqF, gcIrqF;
  logic [IDX_W-1:0] idF;
  logic [1:0]       gcTypeF;
  logic             noAckF, rxOvfF, rxIrqF, txIrqF, txUnfF, txEmptyF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startF <= 1'b0; rptF <= 1'b0; busyF <= 1'b0; stopIrqF <= 1'b0;
      gcIrqF <= 1'b0; idF <= '0; gcTypeF <= 2'b00;
      noAckF <= 1'b0; rxOvfF <= 1'b0; rxIrqF <= 1'b0;
      txIrqF <= 1'b0; txUnfF <= 1'b0; txEmptyF <= 1'b1;
    end else begin
      // clears first, sets afterwards so a set wins
      if (stb.stopEvt) begin
        startF <= 1'b0; rptF <= 1'b0; busyF <= 1'b0;
      end
      if (statusRd) begin
        rptF <= 1'b0; stopIrqF <= 1'b0; noAckF <= 1'b0; rxOvfF <= 1'b0;
      end
      if (rxReadStb || rxFlushStb) rxIrqF <= 1'b0;
      if (txWriteStb) begin
        txIrqF <= 1'b0; txUnfF <= 1'b0; txEmptyF <= 1'b0;
      end
      if (gcClearStb) begin
        gcIrqF <= 1'b0; gcTypeF <= 2'b00;
      end

      if (stb.setStart) startF <= 1'b1;
      if (stb.setRpt)   rptF   <= 1'b1;
      if (stb.loadId)   idF    <= idIdx;
      if (stb.setBusy)  busyF  <= 1'b1;
      if (stb.stopEvt && stb.stopMatched) stopIrqF <= 1'b1;
      if (stb.setGc)      gcIrqF  <= 1'b1;
      if (stb.loadGcType) gcTypeF <= gcTypeDec;
      if (noDataStb)      noAckF  <= 1'b1;
      if (rxOverflowStb)  rxOvfF  <= 1'b1;
      if (rxDataStb)      rxIrqF  <= 1'b1;
      if (txDoneStb)      txIrqF  <= 1'b1;
      if (txUnderflowStb) txUnfF  <= 1'b1;
      if (txEmptyStb)     txEmptyF <= 1'b1;

      // general-call reset returns everything but the call record
      if (stb.gcReset) begin
        startF <= 1'b0; rptF <= 1'b0; busyF <= 1'b0; stopIrqF <= 1'b0;
        idF <= '0; noAckF <= 1'b0; rxOvfF <= 1'b0; rxIrqF <= 1'b0;
        txIrqF <= 1'b0; txUnfF <= 1'b0; txEmptyF <= 1'b1;
      end
    end
  end

  always_comb begin
    status = '0;
    status[BIT_TX_EMPTY] = txEmptyF;
    status[BIT_TX_UNF]   = txUnfF;
    status[BIT_TX_IRQ]   = txIrqF;
    status[BIT_RX_IRQ]   = rxIrqF;
    status[BIT_RX_OVF]   = rxOvfF;
    status[BIT_NOACK]    = noAckF;
    status[BIT_BUSY]     = busyF;
    status[BIT_GC_IRQ]   = gcIrqF;
    status[BIT_GC_TYPE +: 2] = gcTypeF;
    status[BIT_STOP_IRQ] = stopIrqF;
    status[BIT_ID +: IDX_W] = idF;
    status[BIT_RPT]      = rptF;
    status[BIT_START]    = startF;
  end

  assign irq = txIrqF | rxIrqF | gcIrqF | stopIrqF;

endmodule

// File: rtl/i2cs_stat_top.sv
module i2cs_stat_top
  import i2cs_stat_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int NUM_IDS = 4,
  parameter int STAT_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startStb,
  input  logic                      rptStartStb,
  input  logic                      stopStb,
  input  logic                      byteStb,
  input  logic [ADDR_W:0]           rxByte,
  input  logic [NUM_IDS*ADDR_W-1:0] slaveIds,
  input  logic [ADDR_W-1:0]         altId,
  input  logic                      gcEnable,
  input  logic                      gcClearStb,
  input  logic                      statusRd,
  input  logic                      noDataStb,
  input  logic                      rxOverflowStb,
  input  logic                      rxDataStb,
  input  logic                      rxReadStb,
  input  logic                      rxFlushStb,
  input  logic                      txDoneStb,
  input  logic                      txWriteStb,
  input  logic                      txEmptyStb,
  input  logic                      txUnderflowStb,
  output logic [STAT_W-1:0]         status,
  output logic                      irq,
  output logic                      gcResetPulse
);

  ctrlStb_t   stb;
  logic       idHit, gcAddrHit;
  logic [1:0] gcTypeDec;

  i2cs_stat_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .startStb(startStb), .rptStartStb(rptStartStb), .stopStb(stopStb),
    .byteStb(byteStb), .gcEnable(gcEnable),
    .idHit(idHit), .gcAddrHit(gcAddrHit), .gcTypeDec(gcTypeDec),
    .stb(stb), .gcResetPulse(gcResetPulse)
  );

  i2cs_stat_dpath #(.ADDR_W(ADDR_W), .NUM_IDS(NUM_IDS), .STAT_W(STAT_W)) dpath_i (
    .clk(clk), .rstN(rstN),
    .rxByte(rxByte), .slaveIds(slaveIds), .altId(altId), .stb(stb),
    .gcClearStb(gcClearStb), .statusRd(statusRd),
    .noDataStb(noDataStb), .rxOverflowStb(rxOverflowStb),
    .rxDataStb(rxDataStb), .rxReadStb(rxReadStb), .rxFlushStb(rxFlushStb),
    .txDoneStb(txDoneStb), .txWriteStb(txWriteStb),
    .txEmptyStb(txEmptyStb), .txUnderflowStb(txUnderflowStb),
    .idHit(idHit), .gcAddrHit(gcAddrHit), .gcTypeDec(gcTypeDec),
    .status(status), .irq(irq)
  );

endmodule

// File: rtl/i2cs_stat_chk.sv
module i2cs_stat_chk (
  input logic        clk,
  input logic        rstN,
  input logic        stopStb,
  input logic        byteStb,
  input logic        gcClearStb,
  input logic        statusRd,
  input logic        txDoneStb,
  input logic        txWriteStb,
  input logic        txEmptyStb,
  input logic        txUnderflowStb,
  input logic [31:0] status,
  input logic        gcResetPulse
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    status[31:15] == '0); // R10

  AST_STOP_CLEARS_START: assert property (@(posedge clk) disable iff (!rstN)
    stopStb |=> (!status[14] && !status[13] && !status[6])); // R3

  AST_READ_CLEARS_STOPIRQ: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !stopStb) |=> !status[10]); // R3

  AST_GC_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (status[7] && !gcClearStb) |=> status[7]); // R4

  AST_GCRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    gcResetPulse |=> !gcResetPulse); // R6

  AST_GCRST_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    gcResetPulse |-> (status[9:8] == 2'b01)); // R5

  AST_TXWR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (txWriteStb && !txDoneStb && !txEmptyStb && !txUnderflowStb && !byteStb)
      |=> (status[2:0] == 3'b000)); // R9

endmodule

bind i2cs_stat_top i2cs_stat_chk chk_i (
  .clk(clk), .rstN(rstN), .stopStb(stopStb), .byteStb(byteStb),
  .gcClearStb(gcClearStb), .statusRd(statusRd),
  .txDoneStb(txDoneStb), .txWriteStb(txWriteStb),
  .txEmptyStb(txEmptyStb), .txUnderflowStb(txUnderflowStb),
  .status(status), .gcResetPulse(gcResetPulse)
);

// File: tb/i2cs_stat_top_tb_top.sv
module i2cs_stat_top_tb_top;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStb = 0, rptStartStb = 0, stopStb = 0, byteStb = 0;
  logic [7:0]  rxByte = '0;
  logic [27:0] slaveIds;
  logic [6:0]  altId = 7'h33;
  logic gcEnable = 0, gcClearStb = 0, statusRd = 0;
  logic noDataStb = 0, rxOverflowStb = 0, rxDataStb = 0, rxReadStb = 0, rxFlushStb = 0;
  logic txDoneStb = 0, txWriteStb = 0, txEmptyStb = 0, txUnderflowStb = 0;
  logic [31:0] status;
  logic irq, gcResetPulse;

  logic [6:0] ids [4] = '{7'h15, 7'h2A, 7'h2A, 7'h7F};
  assign slaveIds = {ids[3], ids[2], ids[1], ids[0]};

  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  i2cs_stat_top dut_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .rptStartStb(rptStartStb),
    .stopStb(stopStb), .byteStb(byteStb), .rxByte(rxByte), .slaveIds(slaveIds),
    .altId(altId), .gcEnable(gcEnable), .gcClearStb(gcClearStb), .statusRd(statusRd),
    .noDataStb(noDataStb), .rxOverflowStb(rxOverflowStb), .rxDataStb(rxDataStb),
    .rxReadStb(rxReadStb), .rxFlushStb(rxFlushStb), .txDoneStb(txDoneStb),
    .txWriteStb(txWriteStb), .txEmptyStb(txEmptyStb), .txUnderflowStb(txUnderflowStb),
    .status(status), .irq(irq), .gcResetPulse(gcResetPulse)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doStart();  startStb = 1; cyc(); startStb = 0; endtask
  task automatic doRpt();    rptStartStb = 1; cyc(); rptStartStb = 0; endtask
  task automatic doStop();   stopStb = 1; cyc(); stopStb = 0; endtask
  task automatic doRead();   statusRd = 1; cyc(); statusRd = 0; endtask
  task automatic doGcClr();  gcClearStb = 1; cyc(); gcClearStb = 0; endtask
  task automatic doByte(input logic [7:0] b);
    rxByte = b; byteStb = 1; cyc(); byteStb = 0;
  endtask

  function automatic int expIdx(input logic [6:0] a);
    for (int i = 3; i >= 0; i--) if (ids[i] == a) expIdx = i;
    if (ids[0] != a && ids[1] != a && ids[2] != a && ids[3] != a) expIdx = -1;
  endfunction

  function automatic logic [1:0] expGc(input logic [7:0] b);
    if (b == 8'h06) return 2'b01;
    if (b == 8'h04) return 2'b10;
    if (b[0] && b[7:1] == altId) return 2'b11;
    return 2'b00;
  endfunction

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(); cyc(); cyc();
    rstN = 1;
    cyc();
    // R9 R10 reset state
    chk("R9 reset status", status, 32'h1);
    chk("R11 reset irq", {31'b0, irq}, 32'h0);
    chk("R6 reset pulse", {31'b0, gcResetPulse}, 32'h0);

    // R1 R3 R4 R11: sweep every address, general call disabled
    for (int a = 0; a < 128; a++) begin
      int ix;
      ix = expIdx(7'(a));
      doStart();
      doByte({7'(a), 1'b0});
      chk("R1 start bit", {31'b0, status[14]}, {31'b0, ix >= 0});
      chk("R1 busy bit", {31'b0, status[6]}, {31'b0, ix >= 0});
      if (ix >= 0) chk("R1 id field", {30'b0, status[12:11]}, 32'(ix));
      chk("R4 gc disabled", {31'b0, status[7]}, 32'h0);
      doStop();
      chk("R3 stop irq", {31'b0, status[10]}, {31'b0, ix >= 0});
      chk("R3 start cleared", {31'b0, status[14]}, 32'h0);
      chk("R11 irq", {31'b0, irq}, {31'b0, ix >= 0});
      doRead();
      chk("R3 read clears", {31'b0, status[10]}, 32'h0);
      chk("R10 reserved", {15'b0, status[31:15]}, 32'h0);
    end

    // R1: byte without START is ignored
    doByte({ids[0], 1'b0});
    chk("R1 no start", {31'b0, status[14] | status[6]}, 32'h0);
    // R3: STOP with no match
    doStart(); doByte(8'h02); doStop();
    chk("R3 stop no match", {31'b0, status[10]}, 32'h0);

    // R2 repeated start
    doStart(); doByte({ids[0], 1'b0});
    doRpt();   doByte({ids[3], 1'b1});
    chk("R2 rpt set", {30'b0, status[14:13]}, 32'h3);
    chk("R2 id from rpt", {30'b0, status[12:11]}, 32'h3);
    doRead();
    chk("R2 read clears rpt", {30'b0, status[14:13]}, 32'h2);
    doRpt(); doByte({ids[1], 1'b0});
    chk("R2 rpt again", {30'b0, status[12:11]}, 32'h1);
    doStop();
    chk("R2 stop clears rpt", {30'b0, status[14:13]}, 32'h0);
    chk("R3 stop irq after rpt", {31'b0, status[10]}, 32'h1);
    doRead();

    // R4 R5 R6: every second byte of a general call
    gcEnable = 1;
    for (int b = 0; b < 256; b++) begin
      logic [1:0] t;
      t = expGc(8'(b));
      doStart(); doByte(8'h00);
      chk("R4 gc irq", {31'b0, status[7]}, 32'h1);
      noDataStb = 1; cyc(); noDataStb = 0;
      chk("R7 noack set", {31'b0, status[5]}, 32'h1);
      doByte(8'(b));
      chk("R5 gc type", {30'b0, status[9:8]}, {30'b0, t});
      chk("R6 pulse", {31'b0, gcResetPulse}, {31'b0, t == 2'b01});
      chk("R6 noack after", {31'b0, status[5]}, {31'b0, t != 2'b01});
      chk("R6 busy after", {31'b0, status[6]}, {31'b0, t != 2'b01});
      cyc();
      chk("R6 pulse one cycle", {31'b0, gcResetPulse}, 32'h0);
      doStop(); doRead();
      chk("R4 gc sticky", {31'b0, status[7]}, 32'h1);
      doGcClr();
      chk("R4 gc clear", {30'b0, status[8:7]}, 32'h0);
      chk("R5 type clear", {30'b0, status[9:8]}, 32'h0);
    end
    // R4: address 0 with read direction is not a general call
    doStart(); doByte(8'h01);
    chk("R4 read dir", {31'b0, status[7]}, 32'h0);
    doStop(); doRead();

    // R7
    rxOverflowStb = 1; cyc(); rxOverflowStb = 0;
    chk("R7 overflow", {31'b0, status[4]}, 32'h1);
    doRead();
    chk("R7 read clears", {30'b0, status[5:4]}, 32'h0);
    // R8
    rxDataStb = 1; cyc(); rxDataStb = 0;
    chk("R8 rx irq", {30'b0, status[3], irq}, 32'h3);
    rxReadStb = 1; cyc(); rxReadStb = 0;
    chk("R8 rx read clears", {31'b0, status[3]}, 32'h0);
    rxDataStb = 1; cyc(); rxDataStb = 0;
    rxFlushStb = 1; cyc(); rxFlushStb = 0;
    chk("R8 flush clears", {31'b0, status[3]}, 32'h0);
    // R9
    txDoneStb = 1; txUnderflowStb = 1; cyc(); txDoneStb = 0; txUnderflowStb = 0;
    chk("R9 tx flags", {29'b0, status[2:0]}, 32'h7);
    txWriteStb = 1; cyc(); txWriteStb = 0;
    chk("R9 tx write clears", {29'b0, status[2:0]}, 32'h0);
    txEmptyStb = 1; cyc(); txEmptyStb = 0;
    chk("R9 tx empty", {29'b0, status[2:0]}, 32'h1);
    // R12 set wins
    rxDataStb = 1; rxReadStb = 1; noDataStb = 1; statusRd = 1; txDoneStb = 1; txWriteStb = 1;
    cyc();
    rxDataStb = 0; rxReadStb = 0; noDataStb = 0; statusRd = 0; txDoneStb = 0; txWriteStb = 0;
    chk("R12 set wins", {29'b0, status[5], status[3], status[2]}, 32'h7);
    chk("R11 irq on", {31'b0, irq}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule